// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a bank of peripheral interrupt request lines and a small set of non-maskable trap lines into one request to a processor core. Each peripheral source has a 3-bit priority. The block remembers every request until it is serviced. Each cycle it picks one winner: any pending trap goes first. Otherwise it takes the eligible peripheral at the highest priority, and on a tie the lower vector index wins. It then presents the vector number of the winner together with the program address of that vector's slot.

The slot address is taken from a default table or from an alternate table. Both tables have the same layout, and a single control input selects between them for every lookup. The core tells the block its current 3-bit priority. A peripheral is forwarded only when its priority is above that value. The core takes a presented request with a one-cycle acknowledge, which retires the winner's pending flag.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is low, and in the first cycle after it, `req_o` is 0 and `vec_o` and `addr_o` are 0. All pending flags are cleared by reset.
- R2: Any pending trap beats every peripheral. Among traps, the lower trap index wins. Traps are forwarded whatever the core priority is.
- R3: A peripheral with priority field 0 is never forwarded. A peripheral with a nonzero priority is forwarded only if its priority is strictly greater than `cpu_ipl_i`. The priority of peripheral k sits in `prio_i[3k+2:3k]`.
- R4: Among eligible peripherals, the one with the highest priority wins.
- R5: Among eligible peripherals with equal priority, the one with the lower index wins.
- R6: Vector numbering: trap t presents `vec_o` = t (0..7), and peripheral k presents `vec_o` = 8 + k (8..125).
- R7: `addr_o` = 0x000004 + 2·`vec_o` when `alt_tbl_i` is 0. It is 0x000110 + 2·`vec_o` when `alt_tbl_i` is 1, because the alternate base is the default base plus 2·(126 + 8 gap slots). The table used is the one selected in the cycle before the output is registered.
- R8: Outputs are registered with a fixed latency of one clock. A request present in the cycle before a rising edge shows on `req_o`/`vec_o`/`addr_o` right after that edge, whether the source is a trap or a peripheral.
- R9: A one-cycle request pulse stays pending, and stays presented, until it is acknowledged.
- R10: `ack_i` high while `req_o` is 1 clears the pending flag of the presented vector. The next winner, or no request, is presented after that same edge. `ack_i` while `req_o` is 0 changes no pending flag.
- R11: A peripheral masked by the core priority stays pending. It is forwarded once `cpu_ipl_i` drops below its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 8 | Non-maskable trap request lines |
| irq_i | input | 118 | Peripheral interrupt request lines |
| prio_i | input | 354 | Per-peripheral 3-bit priority, source k at bits 3k+2:3k |
| cpu_ipl_i | input | 3 | Current core priority |
| alt_tbl_i | input | 1 | Selects the alternate vector table |
| ack_i | input | 1 | Core acknowledge of the presented request |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 7 | Winning vector number |
| addr_o | output | 24 | Program address of the winning vector slot |

## Verification
A single peripheral pulse confirms numbering, latency and stickiness. Two equal-priority sources tell the natural-order tie-break apart from the priority comparison. Two unequal-priority sources with the higher index holding the higher priority show that priority is decided before index. Traps mixed with a high-priority peripheral, sent while the core priority is at its maximum, separate the trap path from the masked path. Masking at the equal-priority boundary, acknowledges sent with no request presented, table switching on a held request, and vectors 0 and 125 under the alternate table cover the edges of the compare, the handshake and the address arithmetic.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 24;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Start of the selected table: the alternate table follows the default one
  // after all vector slots plus a gap, each slot two address units wide.
  function automatic addr_t table_base(input addr_t dflt, input int unsigned n_vec,
                                       input int unsigned gap, input logic use_alt);
    addr_t span;
    span = addr_t'((n_vec + gap) << 1);
    return use_alt ? (dflt + span) : dflt;
  endfunction

  // Slot address of one vector within a table.
  function automatic addr_t slot_addr(input addr_t base, input int unsigned idx);
    return base + addr_t'(idx << 1);
  endfunction
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] eff_o
);
  logic [N-1:0] pend_q;

  // A new request outranks a clear of the same bit in the same cycle.
  assign eff_o  = (pend_q & ~clr_i) | set_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= eff_o;
  end

  // R9: a pending flag that is not cleared survives the edge
  a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  // R10: a cleared flag with no simultaneous request is gone after the edge
  a_r10_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int N_TRAP = 8,
  parameter int N_IRQ  = 118,
  parameter int VEC_W  = 7
) (
  input  logic [N_TRAP-1:0]       trap_eff_i,
  input  logic [N_IRQ-1:0]        irq_eff_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  prio_t                   ipl_i,
  output logic                    hit_o,
  output logic                    trap_hit_o,
  output logic [VEC_W-1:0]        vec_o
);
  logic [N_IRQ-1:0] elig;
  logic [VEC_W-1:0] trap_idx;
  logic [VEC_W-1:0] irq_idx;
  prio_t            irq_best;
  logic             irq_hit;

  // Per-source mask: a priority must exceed the core's level (0 never does).
  for (genvar k = 0; k < N_IRQ; k++) begin : g_elig
    assign elig[k] = irq_eff_i[k] && (prio_i[k*PRIO_W +: PRIO_W] > ipl_i);
  end

  // Lowest-index trap.
  always_comb begin
    trap_idx = '0;
    for (int i = N_TRAP - 1; i >= 0; i--) begin
      if (trap_eff_i[i]) trap_idx = VEC_W'(i);
    end
  end

  // Highest priority first; ascending scan with strict compare keeps the
  // lowest index among equals.
  always_comb begin
    irq_best = '0;
    irq_idx  = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      if (elig[k] && (prio_i[k*PRIO_W +: PRIO_W] > irq_best)) begin
        irq_best = prio_i[k*PRIO_W +: PRIO_W];
        irq_idx  = VEC_W'(k);
      end
    end
  end

  assign irq_hit    = |elig;
  assign trap_hit_o = |trap_eff_i;
  assign hit_o      = trap_hit_o | irq_hit;
  assign vec_o      = trap_hit_o ? trap_idx : (VEC_W'(N_TRAP) + irq_idx);
endmodule

// File: rtl/ivc_vecgen.sv
module ivc_vecgen
  import ivc_pkg::*;
#(
  parameter int    N_VEC     = 126,
  parameter int    GAP_SLOTS = 8,
  parameter int    VEC_W     = 7,
  parameter addr_t BASE_ADDR = 24'h000004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             alt_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output addr_t            addr_o
);
  localparam addr_t TBL_END = BASE_ADDR + addr_t'((2 * N_VEC + GAP_SLOTS) * 2);

  addr_t base_sel;
  addr_t addr_nxt;

  assign base_sel = table_base(BASE_ADDR, N_VEC, GAP_SLOTS, alt_i);
  assign addr_nxt = slot_addr(base_sel, 32'(vec_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      vec_o  <= '0;
      addr_o <= '0;
    end else if (hit_i) begin
      req_o  <= 1'b1;
      vec_o  <= vec_i;
      addr_o <= addr_nxt;
    end else begin
      req_o  <= 1'b0;
      vec_o  <= '0;
      addr_o <= '0;
    end
  end

  // R7: a presented address is an even slot inside one of the two tables
  a_r7_addr_in_tables: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (addr_o >= BASE_ADDR && addr_o < TBL_END && addr_o[0] == BASE_ADDR[0]));

  // R6: presented vectors stay within the vector space
  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (32'(vec_o) < N_VEC));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import ivc_pkg::*;
#(
  parameter int    N_TRAP    = 8,
  parameter int    N_IRQ     = 118,
  parameter int    GAP_SLOTS = 8,
  parameter addr_t BASE_ADDR = 24'h000004,
  localparam int   N_VEC     = N_TRAP + N_IRQ,
  localparam int   VEC_W     = $clog2(N_VEC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TRAP-1:0]       trap_i,
  input  logic [N_IRQ-1:0]        irq_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       cpu_ipl_i,
  input  logic                    alt_tbl_i,
  input  logic                    ack_i,
  output logic                    req_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [ADDR_W-1:0]       addr_o
);
  logic              ack_fire;
  logic [N_VEC-1:0]  clr_all;
  logic [N_VEC-1:0]  set_all;
  logic [N_VEC-1:0]  pend_all;
  logic [N_TRAP-1:0] trap_pend, trap_eff;
  logic [N_IRQ-1:0]  irq_pend, irq_eff;
  logic              hit, trap_hit;
  logic [VEC_W-1:0]  win_vec;

  // Acknowledge retires the presented vector only while a request is shown.
  assign ack_fire = ack_i & req_o;
  assign clr_all  = ack_fire ? (N_VEC'(1) << vec_o) : '0;
  assign set_all  = {irq_i, trap_i};
  assign pend_all = {irq_pend, trap_pend};

  ivc_pending #(.N(N_TRAP)) u_trap_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(trap_i), .clr_i(clr_all[N_TRAP-1:0]),
    .pend_o(trap_pend), .eff_o(trap_eff)
  );

  ivc_pending #(.N(N_IRQ)) u_irq_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(irq_i), .clr_i(clr_all[N_VEC-1:N_TRAP]),
    .pend_o(irq_pend), .eff_o(irq_eff)
  );

  ivc_arbiter #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_arb (
    .trap_eff_i(trap_eff), .irq_eff_i(irq_eff),
    .prio_i(prio_i), .ipl_i(cpu_ipl_i),
    .hit_o(hit), .trap_hit_o(trap_hit), .vec_o(win_vec)
  );

  ivc_vecgen #(.N_VEC(N_VEC), .GAP_SLOTS(GAP_SLOTS), .VEC_W(VEC_W),
               .BASE_ADDR(BASE_ADDR)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .hit_i(hit), .vec_i(win_vec), .alt_i(alt_tbl_i),
    .req_o(req_o), .vec_o(vec_o), .addr_o(addr_o)
  );

  // R8: a winner this cycle is presented after exactly one edge
  a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> req_o);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !req_o);

  // R2: any pending trap wins over all peripherals
  a_r2_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> (req_o && (32'(vec_o) < N_TRAP)));

  // R10: an accepted vector leaves the pending set unless re-requested
  a_r10_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !set_all[vec_o]) |=> !pend_all[$past(vec_o)]);

  // R10: acknowledge with nothing presented drops no pending flag
  a_r10_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o) |=> ((pend_all & $past(pend_all)) == $past(pend_all)));
endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int NT = 8;
  localparam int NI = 118;
  localparam int DFLT_BASE = 4;
  localparam int ALT_BASE  = 4 + 2 * (126 + 8);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] trap_i;
  logic [NI-1:0] irq_i;
  logic [NI*3-1:0] prio_i;
  logic [2:0]    cpu_ipl_i;
  logic          alt_tbl_i;
  logic          ack_i;
  logic          req_o;
  logic [6:0]    vec_o;
  logic [23:0]   addr_o;
  logic [2:0]    pr [NI];

  int n_chk = 0;
  int n_bad = 0;

  bit    q_req [$];
  int    q_vec [$];
  bit    q_alt [$];
  string q_tag [$];

  always #4 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NI; k++) prio_i[k*3 +: 3] = pr[k];
  end

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .irq_i(irq_i), .prio_i(prio_i),
    .cpu_ipl_i(cpu_ipl_i), .alt_tbl_i(alt_tbl_i), .ack_i(ack_i),
    .req_o(req_o), .vec_o(vec_o), .addr_o(addr_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: inputs are already set at a falling edge; queue the expectation
  // for the next rising edge, then drop the one-cycle pulses.
  task automatic step(input bit er, input int ev, input string tag);
    q_req.push_back(er);
    q_vec.push_back(ev);
    q_alt.push_back(alt_tbl_i);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    trap_i = '0;
    irq_i  = '0;
    ack_i  = 1'b0;
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q_req.size() > 0) begin
      bit    er;
      int    ev;
      bit    ea;
      string tg;
      er = q_req.pop_front();
      ev = q_vec.pop_front();
      ea = q_alt.pop_front();
      tg = q_tag.pop_front();
      check({tg, " req"}, int'(req_o), int'(er));
      if (er) begin
        check({tg, " vec"}, int'(vec_o), ev);
        check({tg, " addr"}, int'(addr_o), (ea ? ALT_BASE : DFLT_BASE) + 2 * ev);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trap_i = '0; irq_i = '0; cpu_ipl_i = 3'd0;
    alt_tbl_i = 1'b0; ack_i = 1'b0;
    for (int k = 0; k < NI; k++) pr[k] = 3'd0;
    irq_i[5] = 1'b1;  pr[5] = 3'd3;           // request during reset must not latch
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(req_o), 0);
    irq_i = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", int'(req_o), 0);
    check("R1 vec after reset", int'(vec_o), 0);
    check("R1 addr after reset", int'(addr_o), 0);
    step(0, 0, "R1 idle");

    // single peripheral: numbering, latency, stickiness, retire
    irq_i[5] = 1'b1;  step(1, 13, "R8 R6 single irq5");
    step(1, 13, "R9 held irq5");
    ack_i = 1'b1;     step(0, 0, "R10 ack irq5");

    // equal priority tie
    pr[10] = 3'd4; pr[3] = 3'd4;
    irq_i[10] = 1'b1; irq_i[3] = 1'b1; step(1, 11, "R5 tie low index");
    ack_i = 1'b1;     step(1, 18, "R10 next after ack");
    ack_i = 1'b1;     step(0, 0, "R10 drained");

    // priority before index
    pr[2] = 3'd2; pr[100] = 3'd6;
    irq_i[2] = 1'b1; irq_i[100] = 1'b1; step(1, 108, "R4 higher prio wins");
    ack_i = 1'b1;     step(1, 10, "R4 lower prio next");
    ack_i = 1'b1;     step(0, 0, "R4 drained");

    // traps over peripherals
    trap_i[5] = 1'b1; trap_i[2] = 1'b1; irq_i[100] = 1'b1;
    step(1, 2, "R2 lowest trap first");
    ack_i = 1'b1;     step(1, 5, "R2 second trap");
    ack_i = 1'b1;     step(1, 108, "R2 irq after traps");
    ack_i = 1'b1;     step(0, 0, "R2 drained");
    cpu_ipl_i = 3'd7;
    trap_i[7] = 1'b1; step(1, 7, "R2 trap ignores ipl");
    ack_i = 1'b1;     step(0, 0, "R2 trap retired");

    // masking at the boundary and release
    cpu_ipl_i = 3'd6;
    irq_i[100] = 1'b1; step(0, 0, "R3 equal prio masked");
    cpu_ipl_i = 3'd5; step(1, 108, "R11 unmasked after ipl drop");
    ack_i = 1'b1;     step(0, 0, "R11 retired");
    cpu_ipl_i = 3'd0;
    irq_i[50] = 1'b1; step(0, 0, "R3 prio zero disabled");

    // ack with nothing presented
    cpu_ipl_i = 3'd7;
    irq_i[5] = 1'b1;  step(0, 0, "R11 irq5 masked");
    ack_i = 1'b1;     step(0, 0, "R10 ack ignored");
    cpu_ipl_i = 3'd0; step(1, 13, "R10 pending survived ack");
    ack_i = 1'b1;     step(0, 0, "R10 irq5 retired");

    // table selection and address extremes
    alt_tbl_i = 1'b1; pr[117] = 3'd1;
    irq_i[117] = 1'b1; step(1, 125, "R7 alt table last vector");
    alt_tbl_i = 1'b0; step(1, 125, "R7 default table last vector");
    ack_i = 1'b1;     step(0, 0, "R7 retired");
    alt_tbl_i = 1'b1;
    trap_i[0] = 1'b1; step(1, 0, "R7 alt table vector zero");
    ack_i = 1'b1;     step(0, 0, "R7 trap0 retired");
    alt_tbl_i = 1'b0;

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule